// File: doc/BRIEF.md
# Pin Port with Selectable Input Capture

This block is a 32-line general-purpose pin port on a single bus clock. Software drives the output lines and their enables through two registers. It reads the pin state back through an input register. A per-line mask, a global enable and a sticky status flag produce an interrupt request when a watched input line changes.

A control register sets how the input register samples the pins. By default the pins are captured on every bus clock. The control register can instead make capture wait for a strobe line, and it picks whether the strobe's rising or falling edge counts. The strobe passes through a two-flop synchroniser, so the whole block runs on one clock. Change detection runs on each capture, so strobe-driven sampling and change interrupts work together.

Top module: `gpio_sampled_port`

## Requirements
- R1: After synchronous reset, every register reads zero, `pin_out`, `pin_oe`, `irq` and `bus_ack` are low.
- R2: With control bit 2 (strobe mode) clear, the input register (word offset 0) captures `pin_in` on every clock, and a read returns the pins as they were on the previous clock.
- R3: With control bit 2 set and bit 3 clear, the input register captures `pin_in` only on a rising strobe edge and keeps its value across pin changes and falling strobe edges. Capture happens on the third clock edge after the strobe changes.
- R4: With control bits 2 and 3 both set, capture happens only on a falling strobe edge, and rising edges leave the input register unchanged.
- R5: A write to offset 1 appears on `pin_out` and a write to offset 2 appears on `pin_oe`, both after the acknowledging edge. Both registers read back what was written.
- R6: A write to offset 0 has no effect on the input register.
- R7: Every clock with `bus_valid` high is followed by `bus_ack` high on the next clock, and `bus_ack` is low after a clock without a request. Read data arrives together with the acknowledge.
- R8: When a capture changes an input bit whose bit is set in the mask register (offset 3), and control bit 0 (global enable) is set, control bit 1 (status) is set and `irq` rises. Changes on bits that are masked off set nothing.
- R9: With control bit 0 clear, input changes set neither the status bit nor `irq`.
- R10: The status bit is sticky, and `irq` stays high after the pins return to their old value. Writing zero to the control register lowers `irq` and clears the status bit.
- R11: The control register (offset 4) reads back only bits 3:0 (bit 0 global enable, bit 1 status, bit 2 strobe mode, bit 3 falling edge). Bit 1 may also be set by software. Offsets 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Request valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Acknowledge, one clock after the request |
| bus_rdata | output | 32 | Read data, valid with the acknowledge |
| pin_in | input | 32 | Input pin levels |
| pin_strobe | input | 1 | Asynchronous capture strobe |
| pin_out | output | 32 | Output levels |
| pin_oe | output | 32 | Output enables |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties watch on every clock that the acknowledge follows each request and that the input register tracks the pins in bus-clock mode. They also check that it holds still in strobe mode when no qualifying edge arrives, that output writes reach the pins, and that an enabled change with the global enable raises the interrupt. The bench scenarios alone cover the strobe latency through the synchroniser, and the choice of rising versus falling edge as seen in read data. They also cover the masking of individual lines, the sticky status with its clear-by-zero, the ignored write to the input offset, and the control register layout.

// File: rtl/gpio_latch_pkg.sv
package gpio_latch_pkg;
  // Word offsets of the register map
  localparam int OFS_IN   = 0;
  localparam int OFS_OUT  = 1;
  localparam int OFS_OE   = 2;
  localparam int OFS_MASK = 3;
  localparam int OFS_CTRL = 4;

  // Control register bit positions
  localparam int CB_GIE  = 0;
  localparam int CB_STAT = 1;
  localparam int CB_EXT  = 2;
  localparam int CB_NEG  = 3;

  // Decide whether the input register samples on this clock.
  function automatic logic capture_enable(input logic ext_mode, input logic neg_sel,
                                          input logic rise, input logic fall);
    if (!ext_mode) return 1'b1;
    return neg_sel ? fall : rise;
  endfunction
endpackage

// File: rtl/pio_strobe_sync.sv
module pio_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_async,
  output logic strobe_rise,
  output logic strobe_fall
);
  localparam int CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain_q;
  logic             synced;
  logic             prev;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[CHAIN-2:0], strobe_async};
  end

  assign synced      = chain_q[STAGES-1];
  assign prev        = chain_q[STAGES];
  assign strobe_rise = synced & ~prev;
  assign strobe_fall = ~synced & prev;
endmodule

// File: rtl/pio_in_latch.sv
module pio_in_latch #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_in,
  input  logic         ext_mode,
  input  logic         neg_sel,
  input  logic         strobe_rise,
  input  logic         strobe_fall,
  input  logic [W-1:0] watch_mask,
  output logic [W-1:0] in_q,
  output logic         change_evt
);
  logic         cap_en;
  logic [W-1:0] diff_bits;

  assign cap_en     = gpio_latch_pkg::capture_enable(ext_mode, neg_sel, strobe_rise, strobe_fall);
  assign diff_bits  = (pin_in ^ in_q) & watch_mask;
  assign change_evt = cap_en & (|diff_bits);

  always_ff @(posedge clk) begin
    if (rst)         in_q <= '0;
    else if (cap_en) in_q <= pin_in;
  end

  AST_BUS_MODE_TRACK: assert property (@(posedge clk) disable iff (rst)
    !ext_mode |=> in_q == $past(pin_in)); // R2
  AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
    ext_mode && !strobe_rise && !strobe_fall |=> $stable(in_q)); // R3
  AST_RISE_IGNORED_ON_NEG: assert property (@(posedge clk) disable iff (rst)
    ext_mode && neg_sel && !strobe_fall |=> $stable(in_q)); // R4
  AST_FALL_IGNORED_ON_POS: assert property (@(posedge clk) disable iff (rst)
    ext_mode && !neg_sel && !strobe_rise |=> $stable(in_q)); // R3
endmodule

// File: rtl/pio_regs.sv
module pio_regs #(
  parameter int W  = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic          bus_ack,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  in_q,
  input  logic          change_evt,
  output logic [W-1:0]  out_q,
  output logic [W-1:0]  oe_q,
  output logic [W-1:0]  mask_q,
  output logic          ext_mode,
  output logic          neg_sel,
  output logic          irq
);
  import gpio_latch_pkg::*;

  localparam logic [AW-1:0] A_IN   = AW'(OFS_IN);
  localparam logic [AW-1:0] A_OUT  = AW'(OFS_OUT);
  localparam logic [AW-1:0] A_OE   = AW'(OFS_OE);
  localparam logic [AW-1:0] A_MASK = AW'(OFS_MASK);
  localparam logic [AW-1:0] A_CTRL = AW'(OFS_CTRL);

  logic         gie_q, stat_q;
  logic         wr_any, wr_out, wr_oe, wr_mask, wr_ctrl;
  logic         irq_set;
  logic [W-1:0] ctrl_word;
  logic [W-1:0] read_mux;

  assign wr_any  = bus_valid & bus_write;
  assign wr_out  = wr_any & (bus_addr == A_OUT);
  assign wr_oe   = wr_any & (bus_addr == A_OE);
  assign wr_mask = wr_any & (bus_addr == A_MASK);
  assign wr_ctrl = wr_any & (bus_addr == A_CTRL);
  assign irq_set = change_evt & gie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q    <= '0;
      oe_q     <= '0;
      mask_q   <= '0;
      gie_q    <= 1'b0;
      stat_q   <= 1'b0;
      ext_mode <= 1'b0;
      neg_sel  <= 1'b0;
    end else begin
      if (wr_out)  out_q  <= bus_wdata;
      if (wr_oe)   oe_q   <= bus_wdata;
      if (wr_mask) mask_q <= bus_wdata;
      if (wr_ctrl) begin
        gie_q    <= bus_wdata[CB_GIE];
        ext_mode <= bus_wdata[CB_EXT];
        neg_sel  <= bus_wdata[CB_NEG];
      end
      if (irq_set)      stat_q <= 1'b1;
      else if (wr_ctrl) stat_q <= bus_wdata[CB_STAT];
    end
  end

  assign irq = stat_q & gie_q;

  always_comb begin
    ctrl_word          = '0;
    ctrl_word[CB_GIE]  = gie_q;
    ctrl_word[CB_STAT] = stat_q;
    ctrl_word[CB_EXT]  = ext_mode;
    ctrl_word[CB_NEG]  = neg_sel;
  end

  always_comb begin
    case (bus_addr)
      A_IN:    read_mux = in_q;
      A_OUT:   read_mux = out_q;
      A_OE:    read_mux = oe_q;
      A_MASK:  read_mux = mask_q;
      A_CTRL:  read_mux = ctrl_word;
      default: read_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack   <= bus_valid;
      bus_rdata <= bus_valid ? read_mux : '0;
    end
  end

  AST_ACK_NEXT: assert property (@(posedge clk) disable iff (rst)
    bus_valid |=> bus_ack); // R7
  AST_ACK_IDLE: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> !bus_ack); // R7
  AST_OUT_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_out |=> out_q == $past(bus_wdata)); // R5
  AST_OE_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_oe |=> oe_q == $past(bus_wdata)); // R5
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    change_evt && gie_q && !wr_ctrl |=> irq); // R8
  AST_CTRL_ZERO_CLEARS: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl && bus_wdata == '0 |=> !irq); // R10
endmodule

// File: rtl/gpio_sampled_port.sv
module gpio_sampled_port #(
  parameter int W           = 32,
  parameter int AW          = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic          bus_ack,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pin_in,
  input  logic          pin_strobe,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic          irq
);
  logic         strobe_rise, strobe_fall;
  logic         ext_mode, neg_sel;
  logic         change_evt;
  logic [W-1:0] in_q, mask_q;

  pio_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk          (clk),
    .rst          (rst),
    .strobe_async (pin_strobe),
    .strobe_rise  (strobe_rise),
    .strobe_fall  (strobe_fall)
  );

  pio_in_latch #(.W(W)) u_latch (
    .clk         (clk),
    .rst         (rst),
    .pin_in      (pin_in),
    .ext_mode    (ext_mode),
    .neg_sel     (neg_sel),
    .strobe_rise (strobe_rise),
    .strobe_fall (strobe_fall),
    .watch_mask  (mask_q),
    .in_q        (in_q),
    .change_evt  (change_evt)
  );

  pio_regs #(.W(W), .AW(AW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_ack    (bus_ack),
    .bus_rdata  (bus_rdata),
    .in_q       (in_q),
    .change_evt (change_evt),
    .out_q      (pin_out),
    .oe_q       (pin_oe),
    .mask_q     (mask_q),
    .ext_mode   (ext_mode),
    .neg_sel    (neg_sel),
    .irq        (irq)
  );
endmodule

// File: tb/gpio_sampled_port_bench.sv
module gpio_sampled_port_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ack;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic        pin_strobe = 1'b0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_sampled_port u_gpio_sampled_port (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_strobe(pin_strobe),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 pin_out", pin_out, 32'h0);
    chk("R1 pin_oe", pin_oe, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 ack", {31'b0, bus_ack}, 32'h0);
    bus_rd(3'd4, v); chk("R1 ctrl", v, 32'h0);
    bus_rd(3'd3, v); chk("R1 mask", v, 32'h0);
  endtask

  task automatic t_outputs;
    logic [31:0] v;
    bus_wr(3'd1, 32'hA5A5_0F0F);
    chk("R5 pin_out", pin_out, 32'hA5A5_0F0F);
    bus_wr(3'd2, 32'h1234_ABCD);
    chk("R5 pin_oe", pin_oe, 32'h1234_ABCD);
    bus_rd(3'd1, v); chk("R5 out readback", v, 32'hA5A5_0F0F);
    bus_rd(3'd2, v); chk("R5 oe readback", v, 32'h1234_ABCD);
  endtask

  task automatic t_bus_mode;
    logic [31:0] v;
    pin_in = 32'hCAFE_0001; wait_clks(2);
    bus_rd(3'd0, v); chk("R2 capture A", v, 32'hCAFE_0001);
    pin_in = 32'h0BAD_F00D; wait_clks(2);
    bus_rd(3'd0, v); chk("R2 capture B", v, 32'h0BAD_F00D);
  endtask

  task automatic t_ctrl_layout;
    logic [31:0] v;
    bus_wr(3'd4, 32'hFFFF_FFFF);
    bus_rd(3'd4, v); chk("R11 ctrl bits", v, 32'h0000_000F);
    chk("R11 sw status irq", {31'b0, irq}, 32'h1);
    bus_wr(3'd4, 32'h0);
    bus_rd(3'd5, v); chk("R11 offset5", v, 32'h0);
    bus_rd(3'd7, v); chk("R11 offset7", v, 32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    pin_in = 32'h0; wait_clks(2);
    bus_wr(3'd3, 32'h0000_00F0);
    bus_wr(3'd4, 32'h1);
    pin_in = 32'h0000_0001; wait_clks(3);
    chk("R8 masked no irq", {31'b0, irq}, 32'h0);
    bus_rd(3'd4, v); chk("R8 masked no status", v, 32'h1);
    pin_in = 32'h0000_0011; wait_clks(3);
    chk("R8 irq raised", {31'b0, irq}, 32'h1);
    bus_rd(3'd4, v); chk("R8 status set", v, 32'h3);
    pin_in = 32'h0000_0001; wait_clks(3);
    pin_in = 32'h0; wait_clks(3);
    chk("R10 sticky", {31'b0, irq}, 32'h1);
    bus_wr(3'd4, 32'h0);
    chk("R10 cleared irq", {31'b0, irq}, 32'h0);
    bus_rd(3'd4, v); chk("R10 cleared status", v, 32'h0);
  endtask

  task automatic t_no_gie;
    logic [31:0] v;
    pin_in = 32'h0000_0030; wait_clks(3);
    chk("R9 no irq", {31'b0, irq}, 32'h0);
    bus_rd(3'd4, v); chk("R9 no status", v, 32'h0);
    pin_in = 32'h0; wait_clks(2);
  endtask

  task automatic t_rise;
    logic [31:0] v;
    pin_in = 32'h1111_1111; wait_clks(2);
    bus_wr(3'd4, 32'h4);
    bus_wr(3'd0, 32'hDEAD_BEEF);
    pin_in = 32'h2222_2222; wait_clks(3);
    bus_rd(3'd0, v); chk("R6 R3 hold", v, 32'h1111_1111);
    pin_strobe = 1'b1; wait_clks(5);
    bus_rd(3'd0, v); chk("R3 rising capture", v, 32'h2222_2222);
    pin_in = 32'h3333_3333;
    pin_strobe = 1'b0; wait_clks(5);
    bus_rd(3'd0, v); chk("R3 falling ignored", v, 32'h2222_2222);
    pin_strobe = 1'b1; wait_clks(5);
    bus_rd(3'd0, v); chk("R3 second rise", v, 32'h3333_3333);
  endtask

  task automatic t_fall;
    logic [31:0] v;
    bus_wr(3'd4, 32'hC);
    pin_in = 32'h4444_0000;
    pin_strobe = 1'b0; wait_clks(5);
    bus_rd(3'd0, v); chk("R4 falling capture", v, 32'h4444_0000);
    pin_in = 32'h5555_0000;
    pin_strobe = 1'b1; wait_clks(5);
    bus_rd(3'd0, v); chk("R4 rising ignored", v, 32'h4444_0000);
    pin_strobe = 1'b0; wait_clks(5);
    bus_rd(3'd0, v); chk("R4 second fall", v, 32'h5555_0000);
  endtask

  task automatic t_irq_ext;
    logic [31:0] v;
    bus_wr(3'd4, 32'h0);
    pin_in = 32'h0; wait_clks(2);
    bus_wr(3'd3, 32'h0000_0001);
    bus_wr(3'd4, 32'h5);
    pin_in = 32'h0000_0001; wait_clks(5);
    chk("R8 R3 no edge no irq", {31'b0, irq}, 32'h0);
    pin_strobe = 1'b1; wait_clks(5);
    chk("R8 irq on strobe capture", {31'b0, irq}, 32'h1);
    bus_rd(3'd0, v); chk("R3 strobe value", v, 32'h0000_0001);
    bus_wr(3'd4, 32'h0);
    chk("R10 clear after ext", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_ack;
    logic [31:0] v;
    bus_rd(3'd1, v);
    chk("R7 ack with read", {31'b0, bus_ack}, 32'h1);
    @(negedge clk);
    chk("R7 ack drops", {31'b0, bus_ack}, 32'h0);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 3'd1;
    @(negedge clk);
    chk("R7 b2b ack 1", {31'b0, bus_ack}, 32'h1);
    chk("R7 b2b data 1", bus_rdata, 32'hA5A5_0F0F);
    bus_addr = 3'd2;
    @(negedge clk);
    chk("R7 b2b ack 2", {31'b0, bus_ack}, 32'h1);
    chk("R7 b2b data 2", bus_rdata, 32'h1234_ABCD);
    bus_valid = 1'b0;
    @(negedge clk);
    chk("R7 idle ack", {31'b0, bus_ack}, 32'h0);
  endtask

  initial begin
    wait_clks(3);
    rst = 1'b0;
    t_reset();
    t_outputs();
    t_bus_mode();
    t_ctrl_layout();
    t_irq();
    t_no_gie();
    t_rise();
    t_fall();
    t_irq_ext();
    t_ack();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule